// File: doc/BRIEF.md
# Bus Burst Fault Capture Register

This block sits beside the master port of a pipelined system bus. It follows the address and data phases of every transfer. For each incrementing burst it counts how many beats have finished with an OKAY response. When the slave answers a tracked burst with an ERROR response, the block freezes a picture of the failing burst in one 32-bit status word:

- the burst code that was on the bus in the failing transfer's address phase;
- the number of beats the burst should have had;
- the number of beats that finished before the failing one.

A flag bit marks the picture as valid. The picture stays put until software writes the flag to zero. That same write wipes the word.

The status word is always visible on an output. Software changes it through a small write port made of an enable, an 8-bit offset and a 32-bit data word. Only a write at the register's own offset that carries a zero in the flag bit has any effect.

Top module: `burst_fault_capture`

## Requirements
- R1: After reset, `status` reads 32'h0000_0000.
- R2: An ERROR response is recognised only on its first cycle (`hresp`=1 with `hready`=0) while a tracked data phase is in flight. In that cycle `status[31]` sets, and the fields are captured.
- R3: `status[11:9]` holds the `hburst` value of the failing transfer's address phase: 3'b011 for INCR4, 3'b101 for INCR8, 3'b111 for INCR16.
- R4: `status[8:4]` holds the expected beat count of the captured burst: 4 for INCR4, 8 for INCR8, 16 for INCR16. It holds 0 while nothing is captured, and never any other value.
- R5: `status[3:0]` holds the number of beats of the failing burst that completed with OKAY before the error beat. The count restarts at every accepted NONSEQ transfer (`htrans`=2'b10). SEQ transfers are `htrans`=2'b11.
- R6: An error during an untracked burst type (SINGLE 3'b000, INCR 3'b001, WRAP4 3'b010 and the other wrapping types) leaves `status` unchanged.
- R7: While `status[31]` is set, later errors leave the whole of `status` unchanged.
- R8: A write with `reg_we`=1, `reg_addr`=8'hA8 and `reg_wdata[31]`=0 clears all of `status` on the next edge. A write with `reg_wdata[31]`=1, whatever the other data bits, has no effect. A write at any other offset has no effect.
- R9: `status[30:12]` always reads 0.
- R10: With `TRACK_INCR4_ONLY`=1 only INCR4 bursts are tracked, so `status[8:4]` is only ever 0 or 4.
- R11: A wait-state cycle (`hready`=0 with `hresp`=0) does not advance the beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| htrans | input | 2 | Transfer type from the master |
| hburst | input | 3 | Burst type from the master |
| hready | input | 1 | Transfer-done strobe from the bus |
| hresp | input | 1 | Response, 1 = ERROR |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Captured fault status word |

## Verification
The bench drives whole bursts of each incrementing length with the failure placed on different beats: the first beat, a middle beat and the final beat of an INCR16. A failure on the first beat shows that the count restarts at NONSEQ, and a failure on the last beat exercises the top of the count field. A wait state inserted mid-burst tells apart counting completed beats from counting cycles. Errors on SINGLE, INCR and WRAP4 bursts, a second error while the flag is set, and writes with the flag bit at one or at a foreign offset each check that the stimulus leaves the word alone. A second instance in INCR4-only mode sees the same traffic and must ignore the INCR8 and INCR16 failures.

// File: rtl/burst_fault_capture.sv
module burst_fault_capture #(
  parameter bit         TRACK_INCR4_ONLY = 1'b0,
  parameter logic [7:0] REG_OFFSET       = 8'hA8,
  parameter int         CNT_W            = 4,
  parameter int         LEN_W            = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  htrans,
  input  logic [2:0]  hburst,
  input  logic        hready,
  input  logic        hresp,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] status
);
  localparam logic [1:0]  TR_NONSEQ = 2'b10;
  localparam logic [2:0]  BT_INCR4  = 3'b011;
  localparam logic [2:0]  BT_INCR8  = 3'b101;
  localparam logic [2:0]  BT_INCR16 = 3'b111;
  localparam logic [31:0] FLAG_MASK = 32'h8000_0000;

  function automatic logic [LEN_W-1:0] beats_of(input logic [2:0] b);
    case (b)
      BT_INCR4:  beats_of = LEN_W'(4);
      BT_INCR8:  beats_of = TRACK_INCR4_ONLY ? '0 : LEN_W'(8);
      BT_INCR16: beats_of = TRACK_INCR4_ONLY ? '0 : LEN_W'(16);
      default:   beats_of = '0;
    endcase
  endfunction

  logic             dp_valid;
  logic [2:0]       dp_burst;
  logic [CNT_W-1:0] beat_cnt;
  logic             flag;
  logic [2:0]       cap_burst;
  logic [LEN_W-1:0] cap_len;
  logic [CNT_W-1:0] cap_cnt;

  wire addr_taken = hready && htrans[1];
  wire beat_ok    = dp_valid && hready && !hresp;
  wire err_first  = dp_valid && hresp && !hready;
  wire sw_clear   = reg_we && (reg_addr == REG_OFFSET) && ((reg_wdata & FLAG_MASK) == '0);
  wire flag_kept  = flag && !sw_clear;
  wire capture    = err_first && (beats_of(dp_burst) != '0) && !flag_kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_burst <= '0;
      beat_cnt <= '0;
    end else begin
      if (hready) dp_valid <= htrans[1];
      if (addr_taken) dp_burst <= hburst;
      if (addr_taken && htrans == TR_NONSEQ) beat_cnt <= '0;
      else if (beat_ok) beat_cnt <= beat_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag      <= 1'b0;
      cap_burst <= '0;
      cap_len   <= '0;
      cap_cnt   <= '0;
    end else if (capture) begin
      flag      <= 1'b1;
      cap_burst <= dp_burst;
      cap_len   <= beats_of(dp_burst);
      cap_cnt   <= beat_cnt;
    end else if (sw_clear) begin
      flag      <= 1'b0;
      cap_burst <= '0;
      cap_len   <= '0;
      cap_cnt   <= '0;
    end
  end

  assign status = {flag, 19'b0, cap_burst, cap_len, cap_cnt};
endmodule

// File: rtl/burst_fault_capture_chk.sv
module burst_fault_capture_chk #(
  parameter bit         TRACK_INCR4_ONLY = 1'b0,
  parameter logic [7:0] REG_OFFSET       = 8'hA8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hready,
  input logic        hresp,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] status
);
  wire clr_wr = reg_we && reg_addr == REG_OFFSET && !reg_wdata[31];

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[30:12] == '0);

  assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[8:4] == 5'd0 || status[8:4] == 5'd4 || status[8:4] == 5'd8 || status[8:4] == 5'd16);

  assert_incr4_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !TRACK_INCR4_ONLY || status[8:4] == 5'd0 || status[8:4] == 5'd4);

  assert_idle_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status[31] |-> status[11:0] == '0);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31] && !clr_wr) |=> $stable(status));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(hresp && !hready)) |=> status == '0);
endmodule

bind burst_fault_capture burst_fault_capture_chk #(
  .TRACK_INCR4_ONLY(TRACK_INCR4_ONLY),
  .REG_OFFSET(REG_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hready(hready), .hresp(hresp),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status)
);

// File: tb/test_burst_fault_capture.sv
module test_burst_fault_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic [2:0]  hburst = 3'b000;
  logic        hready = 1'b1;
  logic        hresp = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] status, status_r4;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  burst_fault_capture i_burst_fault_capture (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .hready(hready),
    .hresp(hresp), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(status));

  burst_fault_capture #(.TRACK_INCR4_ONLY(1'b1)) i_burst_fault_capture_r4 (
    .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .hready(hready),
    .hresp(hresp), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status(status_r4));

  function automatic logic [31:0] expect_word(input logic [2:0] b, input int len, input int cnt);
    return {1'b1, 19'b0, b, 5'(len), 4'(cnt)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] tr, input logic rdy, input logic rsp);
    @(negedge clk);
    htrans = tr; hready = rdy; hresp = rsp;
  endtask

  task automatic run_burst(input logic [2:0] b, input int len, input int err_at, input int wait_at);
    @(negedge clk);
    hburst = b;
    for (int j = 0; j <= len; j++) begin
      logic [1:0] tr;
      tr = (j == len) ? 2'b00 : (j == 0 ? 2'b10 : 2'b11);
      if (j >= 1 && j - 1 == wait_at) cyc(tr, 1'b0, 1'b0);
      if (j >= 1 && j - 1 == err_at) begin
        cyc(tr, 1'b0, 1'b1);
        cyc(2'b00, 1'b1, 1'b1);
        break;
      end
      cyc(tr, 1'b1, 1'b0);
    end
    cyc(2'b00, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", status, 32'h0);
    check("R1 reset r4", status_r4, 32'h0);
  endtask

  task automatic t_clean_burst;
    run_burst(3'b011, 4, -1, -1);
    check("R2 no error", status, 32'h0);
  endtask

  task automatic t_incr4_mid;
    run_burst(3'b011, 4, 2, -1);
    check("R3 R4 R5 incr4 beat2", status, expect_word(3'b011, 4, 2));
    check("R10 incr4 tracked in r4", status_r4, expect_word(3'b011, 4, 2));
    reg_write(8'hA8, 32'h0);
    check("R8 clear", status, 32'h0);
  endtask

  task automatic t_incr8_wait;
    run_burst(3'b101, 8, 5, 1);
    check("R11 R4 incr8 with wait", status, expect_word(3'b101, 8, 5));
    check("R10 incr8 ignored in r4", status_r4, 32'h0);
    reg_write(8'hA8, 32'h0);
  endtask

  task automatic t_incr16_last_then_sticky;
    run_burst(3'b111, 16, 15, -1);
    check("R4 R5 incr16 last beat", status, expect_word(3'b111, 16, 15));
    check("R10 incr16 ignored in r4", status_r4, 32'h0);
    run_burst(3'b011, 4, 1, -1);
    check("R7 sticky", status, expect_word(3'b111, 16, 15));
    check("R9 reserved zero", status & 32'h7FFF_F000, 32'h0);
    reg_write(8'hA8, 32'h0);
    check("R8 clear after sticky", status, 32'h0);
  endtask

  task automatic t_first_beat;
    run_burst(3'b101, 8, 0, -1);
    check("R5 error on first beat", status, expect_word(3'b101, 8, 0));
    reg_write(8'hA8, 32'h0);
  endtask

  task automatic t_untracked;
    run_burst(3'b001, 6, 2, -1);
    check("R6 INCR ignored", status, 32'h0);
    run_burst(3'b000, 1, 0, -1);
    check("R6 SINGLE ignored", status, 32'h0);
    run_burst(3'b010, 4, 3, -1);
    check("R6 WRAP4 ignored", status, 32'h0);
  endtask

  task automatic t_writes;
    run_burst(3'b011, 4, 3, -1);
    check("R2 capture for write test", status, expect_word(3'b011, 4, 3));
    reg_write(8'hA8, 32'hFFFF_FFFF);
    check("R8 write one no effect", status, expect_word(3'b011, 4, 3));
    reg_write(8'hA4, 32'h0);
    check("R8 other offset ignored", status, expect_word(3'b011, 4, 3));
    reg_write(8'hA8, 32'h7FFF_F000);
    check("R8 R9 clear with junk bits", status, 32'h0);
    reg_write(8'hA8, 32'h8000_0FFF);
    check("R8 set attempt ignored", status, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean_burst();
    t_incr4_mid();
    t_incr8_wait();
    t_incr16_last_then_sticky();
    t_first_beat();
    t_untracked();
    t_writes();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule